// File: doc/BRIEF.md
# Last-Level Cache Bank Power Gating and Request Redirection Controller

This block runs the power policy of a last-level cache split into sixteen banks. During each epoch it counts the accesses that reach every bank. At the epoch boundary it can turn off the least-used bank to save leakage power, as long as measured performance loss stays within a bound. Requests addressed to a bank that is off are steered to an active target bank. The target is the powered bank nearest on the on-chip mesh. When performance loss climbs past the bound, the controller powers an idle bank back up. It then asks the data mover to bring that bank's lines home from the target.

The controller makes at most one decision per epoch. Three policy modes set when resizing is allowed. The free mode may shrink or grow the cache at any epoch. The one-shot mode stops shrinking for good after the first restart. The windowed mode behaves like the free mode, except that it freezes all resizing during a repeating window of epochs. A combinational lookup port turns a home bank number into the bank that should serve it. While a restarted bank is still being refilled, the lookup port reports a stall for that bank.

Top module: `bank_pm_ctrl`

## Requirements
- R1: After synchronous reset, all banks are powered, every remap entry holds its own bank index, no lookup stalls, and `mig_req` is low.
- R2: Each bank counts its `acc_stb` pulses in the epoch (saturating at 2^CNT_W-1). At an `epoch_tick` that shuts a bank down, the bank turned off is the one with the fewest accesses among eligible banks, with ties going to the lower index. Counters restart at the tick, and a strobe in the tick cycle counts toward the new epoch. A bank is eligible when it is powered, not stalled, and not a target.
- R3: A shutdown happens only when `perf_loss <= loss_thr` and the number of banks off is below min(`max_off`, NBANK-1).
- R4: The target given to a bank being shut down is the powered bank, other than itself, with the smallest Manhattan distance. Bank i sits at column i mod MESH_COLS and row i div MESH_COLS. Ties in distance go to the lower index. The target is never a bank that is off.
- R5: `remap_tbl[i*IDX_W +: IDX_W]` holds bank i's target while bank i is off or stalled, and i otherwise. For a bank that is off, `lk_eff` returns the target. For a powered bank that is not stalled, `lk_eff` returns the bank itself.
- R6: At an `epoch_tick` with `perf_loss > loss_thr`, the lowest-index bank that is off is powered up. In the cycle after that tick, `mig_req` pulses for one cycle with `mig_home` set to that bank and `mig_tgt` set to its target.
- R7: A restarted bank stalls lookups (`lk_stall`=1, `lk_eff`=home) until `mig_ack` arrives with `mig_ack_bank` naming it. After that, its remap entry returns to its own index.
- R8: Bank power changes only at the clock edge where `epoch_tick` is high, and by at most one bank at that edge.
- R9: Mode 1 (one-shot) blocks every shutdown after the first restart since reset. Restarts are still allowed. Mode 0 (and 3) places no such limit.
- R10: Mode 2 (windowed) blocks both shutdown and restart at a tick where a phase counter is below `frz_len`. The counter starts at 0 at reset and advances at each tick, wrapping to 0 after `frz_period`-1. A `frz_period` of 0 disables the freeze.
- R11: A bank that is the target of another bank that is off or stalled is never shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | NBANK | Per-bank access strobe, one count per cycle |
| epoch_tick | input | 1 | One-cycle epoch boundary, decision point |
| perf_loss | input | PERF_W | Measured performance degradation |
| loss_thr | input | PERF_W | Allowed degradation bound |
| max_off | input | OFF_W | Maximum number of banks allowed off |
| pm_mode | input | 2 | 0 free, 1 one-shot, 2 windowed, 3 as 0 |
| frz_period | input | PH_W | Freeze window period in epochs |
| frz_len | input | PH_W | Frozen epochs at the start of each period |
| lk_bank | input | IDX_W | Home bank to look up |
| lk_eff | output | IDX_W | Bank that serves the lookup |
| lk_stall | output | 1 | Home bank is being refilled; hold the request |
| bank_pwr_en | output | NBANK | Per-bank power enable |
| remap_tbl | output | NBANK*IDX_W | Home-to-target table, entry i at bits i*IDX_W |
| mig_req | output | 1 | One-cycle move-back request |
| mig_home | output | IDX_W | Bank to refill |
| mig_tgt | output | IDX_W | Bank holding its lines |
| mig_ack | input | 1 | Move-back done |
| mig_ack_bank | input | IDX_W | Bank whose move-back is done |

## Verification
A wrong counter, a wrong victim choice or a wrong distance tie-break shows up on `bank_pwr_en` and in the remap table one cycle after the tick that decides. It also spreads into every later epoch, because the target set protects banks from shutdown. A stale busy or remap bit shows up at once on the lookup port as a wrong stall or a redirect to a wrong bank. The bench therefore compares the power vector, all sixteen table entries and a full lookup sweep after every tick and every acknowledge. Mode errors appear as a power change, or a missing one, at the first tick inside a frozen window or after the first restart.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        PM_FREE    = 2'd0,
        PM_ONESHOT = 2'd1,
        PM_WINDOW  = 2'd2,
        PM_SPARE   = 2'd3
    } pm_mode_e;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_SLEEP = 2'd1,
        ACT_WAKE  = 2'd2
    } pm_act_e;

    function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Manhattan hop count between two banks laid out row-major on a mesh
    function automatic int unsigned mesh_dist(input int unsigned a, input int unsigned b,
                                              input int unsigned cols);
        return abs_diff(a % cols, b % cols) + abs_diff(a / cols, b / cols);
    endfunction

endpackage

// File: rtl/bpm_access_counters.sv
module bpm_access_counters #(
    parameter int NBANK = 16,
    parameter int CNT_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NBANK-1:0]             acc_stb,
    input  logic                         epoch_tick,
    output logic [NBANK-1:0][CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < NBANK; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (epoch_tick) begin
                cnt[g] <= {{(CNT_W-1){1'b0}}, acc_stb[g]};
            end else if (acc_stb[g] && cnt[g] != CNT_MAX) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpm_victim_pick.sv
module bpm_victim_pick #(
    parameter int NBANK = 16,
    parameter int CNT_W = 8,
    parameter int IDX_W = 4
) (
    input  logic [NBANK-1:0][CNT_W-1:0] cnt,
    input  logic [NBANK-1:0]            elig,
    output logic                        vld,
    output logic [IDX_W-1:0]            idx
);
    logic [CNT_W-1:0] best;

    // strict less-than keeps the lowest index on equal counts
    always_comb begin
        vld  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (elig[i] && (!vld || cnt[i] < best)) begin
                vld  = 1'b1;
                best = cnt[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bpm_target_pick.sv
module bpm_target_pick
    import bpm_pkg::*;
#(
    parameter int NBANK     = 16,
    parameter int IDX_W     = 4,
    parameter int MESH_COLS = 4
) (
    input  logic [IDX_W-1:0] home,
    input  logic [NBANK-1:0] avail,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);
    int unsigned best_d;
    int unsigned cur_d;

    always_comb begin
        vld    = 1'b0;
        idx    = '0;
        best_d = 0;
        cur_d  = 0;
        for (int i = 0; i < NBANK; i++) begin
            cur_d = mesh_dist(int'(home), i, MESH_COLS);
            if (avail[i] && (!vld || cur_d < best_d)) begin
                vld    = 1'b1;
                best_d = cur_d;
                idx    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bank_pm_ctrl.sv
module bank_pm_ctrl
    import bpm_pkg::*;
#(
    parameter  int NBANK     = 16,
    parameter  int CNT_W     = 8,
    parameter  int PERF_W    = 8,
    parameter  int PH_W      = 4,
    parameter  int MESH_COLS = 4,
    localparam int IDX_W     = $clog2(NBANK),
    localparam int OFF_W     = $clog2(NBANK + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NBANK-1:0]        acc_stb,
    input  logic                    epoch_tick,
    input  logic [PERF_W-1:0]       perf_loss,
    input  logic [PERF_W-1:0]       loss_thr,
    input  logic [OFF_W-1:0]        max_off,
    input  logic [1:0]              pm_mode,
    input  logic [PH_W-1:0]         frz_period,
    input  logic [PH_W-1:0]         frz_len,
    input  logic [IDX_W-1:0]        lk_bank,
    output logic [IDX_W-1:0]        lk_eff,
    output logic                    lk_stall,
    output logic [NBANK-1:0]        bank_pwr_en,
    output logic [NBANK*IDX_W-1:0]  remap_tbl,
    output logic                    mig_req,
    output logic [IDX_W-1:0]        mig_home,
    output logic [IDX_W-1:0]        mig_tgt,
    input  logic                    mig_ack,
    input  logic [IDX_W-1:0]        mig_ack_bank
);
    localparam logic [OFF_W-1:0] OFF_CAP = OFF_W'(NBANK - 1);

    // ---------------- state ----------------
    logic [NBANK-1:0] pwr_q;
    logic [NBANK-1:0] busy_q;
    logic [IDX_W-1:0] tgt_q [NBANK];
    logic [OFF_W-1:0] off_cnt_q;
    logic             locked_q;
    logic [PH_W-1:0]  phase_q;
    logic             mig_req_q;
    logic [IDX_W-1:0] mig_home_q;
    logic [IDX_W-1:0] mig_tgt_q;

    // ---------------- epoch statistics ----------------
    logic [NBANK-1:0][CNT_W-1:0] cnt;

    bpm_access_counters #(.NBANK(NBANK), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .acc_stb    (acc_stb),
        .epoch_tick (epoch_tick),
        .cnt        (cnt)
    );

    // ---------------- eligibility ----------------
    logic [NBANK-1:0] is_tgt;
    logic [NBANK-1:0] elig;

    always_comb begin
        is_tgt = '0;
        for (int j = 0; j < NBANK; j++) begin
            for (int i = 0; i < NBANK; i++) begin
                if ((!pwr_q[i] || busy_q[i]) && tgt_q[i] == IDX_W'(j)) begin
                    is_tgt[j] = 1'b1;
                end
            end
        end
        elig = pwr_q & ~busy_q & ~is_tgt;
    end

    logic             vic_vld;
    logic [IDX_W-1:0] vic_idx;

    bpm_victim_pick #(.NBANK(NBANK), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_vic (
        .cnt  (cnt),
        .elig (elig),
        .vld  (vic_vld),
        .idx  (vic_idx)
    );

    logic [NBANK-1:0] tgt_avail;
    logic             tsel_vld;
    logic [IDX_W-1:0] tsel_idx;

    assign tgt_avail = pwr_q & ~(NBANK'(1) << vic_idx);

    bpm_target_pick #(.NBANK(NBANK), .IDX_W(IDX_W), .MESH_COLS(MESH_COLS)) u_tgt (
        .home  (vic_idx),
        .avail (tgt_avail),
        .vld   (tsel_vld),
        .idx   (tsel_idx)
    );

    // ---------------- restart candidate ----------------
    logic             wake_vld;
    logic [IDX_W-1:0] wake_idx;

    always_comb begin
        wake_vld = 1'b0;
        wake_idx = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (!pwr_q[i]) begin
                wake_vld = 1'b1;
                wake_idx = IDX_W'(i);
            end
        end
    end

    // ---------------- policy ----------------
    pm_mode_e         mode;
    logic             frozen;
    logic [PH_W:0]    ph_inc;
    logic [PH_W-1:0]  phase_nxt;
    logic [OFF_W-1:0] off_limit;
    logic             over_thr;
    logic             may_sleep;
    pm_act_e          act;

    assign mode = pm_mode_e'(pm_mode);

    always_comb begin
        ph_inc    = {1'b0, phase_q} + 1'b1;
        phase_nxt = (frz_period == '0 || ph_inc >= {1'b0, frz_period}) ? '0 : ph_inc[PH_W-1:0];
        frozen    = (mode == PM_WINDOW) && (frz_period != '0) && (phase_q < frz_len);
        off_limit = (max_off > OFF_CAP) ? OFF_CAP : max_off;
        over_thr  = perf_loss > loss_thr;
        may_sleep = !((mode == PM_ONESHOT) && locked_q) && (off_cnt_q < off_limit)
                    && vic_vld && tsel_vld;
        act = ACT_IDLE;
        if (epoch_tick && !frozen) begin
            if (over_thr) begin
                if (wake_vld) act = ACT_WAKE;
            end else if (may_sleep) begin
                act = ACT_SLEEP;
            end
        end
    end

    // ---------------- state update ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q      <= '1;
            busy_q     <= '0;
            off_cnt_q  <= '0;
            locked_q   <= 1'b0;
            phase_q    <= '0;
            mig_req_q  <= 1'b0;
            mig_home_q <= '0;
            mig_tgt_q  <= '0;
            for (int i = 0; i < NBANK; i++) tgt_q[i] <= IDX_W'(i);
        end else begin
            mig_req_q <= 1'b0;
            if (epoch_tick) phase_q <= phase_nxt;
            if (mig_ack && busy_q[mig_ack_bank]) begin
                busy_q[mig_ack_bank] <= 1'b0;
                tgt_q[mig_ack_bank]  <= mig_ack_bank;
            end
            case (act)
                ACT_SLEEP: begin
                    pwr_q[vic_idx] <= 1'b0;
                    tgt_q[vic_idx] <= tsel_idx;
                    off_cnt_q      <= off_cnt_q + 1'b1;
                end
                ACT_WAKE: begin
                    pwr_q[wake_idx]  <= 1'b1;
                    busy_q[wake_idx] <= 1'b1;
                    off_cnt_q        <= off_cnt_q - 1'b1;
                    locked_q         <= 1'b1;
                    mig_req_q        <= 1'b1;
                    mig_home_q       <= wake_idx;
                    mig_tgt_q        <= tgt_q[wake_idx];
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    for (genvar g = 0; g < NBANK; g++) begin : g_tbl
        assign remap_tbl[g*IDX_W +: IDX_W] = tgt_q[g];
    end

    assign bank_pwr_en = pwr_q;
    assign lk_stall    = busy_q[lk_bank];
    assign lk_eff      = busy_q[lk_bank] ? lk_bank : tgt_q[lk_bank];
    assign mig_req     = mig_req_q;
    assign mig_home    = mig_home_q;
    assign mig_tgt     = mig_tgt_q;

endmodule

// File: rtl/bpm_checker.sv
module bpm_checker #(
    parameter int NBANK  = 16,
    parameter int PERF_W = 8,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              epoch_tick,
    input logic [PERF_W-1:0] perf_loss,
    input logic [PERF_W-1:0] loss_thr,
    input logic [NBANK-1:0]  bank_pwr_en,
    input logic [IDX_W-1:0]  lk_bank,
    input logic [IDX_W-1:0]  lk_eff,
    input logic              lk_stall,
    input logic              mig_req,
    input logic [IDX_W-1:0]  mig_home
);
    logic [NBANK-1:0] pwr_d;

    always_ff @(posedge clk) begin
        if (rst) pwr_d <= '1;
        else     pwr_d <= bank_pwr_en;
    end

    // R8
    pwr_one_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_pwr_en ^ pwr_d) <= 1);

    // R8
    pwr_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_pwr_en != pwr_d) |-> $past(epoch_tick));

    // R3
    sleep_in_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (|(pwr_d & ~bank_pwr_en)) |-> $past(perf_loss <= loss_thr));

    // R6
    wake_over_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (|(~pwr_d & bank_pwr_en)) |-> $past(perf_loss > loss_thr));

    // R6
    mig_home_woke_chk: assert property (@(posedge clk) disable iff (rst)
        mig_req |-> (bank_pwr_en[mig_home] && !pwr_d[mig_home]));

    // R4
    eff_powered_chk: assert property (@(posedge clk) disable iff (rst)
        bank_pwr_en[lk_eff]);

    // R7
    stall_home_chk: assert property (@(posedge clk) disable iff (rst)
        lk_stall |-> (lk_eff == lk_bank));

endmodule

bind bank_pm_ctrl bpm_checker #(.NBANK(NBANK), .PERF_W(PERF_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_bank_pm_ctrl.sv
`timescale 1ns/1ps
module sim_bank_pm_ctrl;
    localparam int NB = 16;
    localparam int IW = 4;
    localparam int OW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NB-1:0] acc_stb = '0;
    logic epoch_tick = 1'b0;
    logic [7:0] perf_loss = '0;
    logic [7:0] loss_thr = 8'd20;
    logic [OW-1:0] max_off = '0;
    logic [1:0] pm_mode = 2'd0;
    logic [3:0] frz_period = '0;
    logic [3:0] frz_len = '0;
    logic [IW-1:0] lk_bank = '0;
    logic [IW-1:0] lk_eff;
    logic lk_stall;
    logic [NB-1:0] bank_pwr_en;
    logic [NB*IW-1:0] remap_tbl;
    logic mig_req;
    logic [IW-1:0] mig_home, mig_tgt;
    logic mig_ack = 1'b0;
    logic [IW-1:0] mig_ack_bank = '0;

    always #4 clk = ~clk;

    bank_pm_ctrl u0 (.*);

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    int m_on [NB];
    int m_busy [NB];
    int m_tgt [NB];
    int m_locked;
    int m_phase;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int pat_cnt(input int pat, input int i);
        if (pat == 0) return 3;
        return (i * (2 * pat + 1) + pat * 5) % 9;
    endfunction

    function automatic int m_is_tgt(input int j);
        for (int k = 0; k < NB; k++)
            if ((!m_on[k] || m_busy[k]) && m_tgt[k] == j) return 1;
        return 0;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_on[i] = 1; m_busy[i] = 0; m_tgt[i] = i;
        end
        m_locked = 0;
        m_phase = 0;
    endtask

    function automatic int exp_pwr();
        int v = 0;
        for (int i = 0; i < NB; i++) if (m_on[i] != 0) v |= (1 << i);
        return v;
    endfunction

    task automatic check_all(input string ptag, input int exp_mig, input int eh, input int et);
        chk("R6", "mig_req", int'(mig_req), exp_mig);
        if (exp_mig != 0) begin
            chk("R6", "mig_home", int'(mig_home), eh);
            chk("R6", "mig_tgt", int'(mig_tgt), et);
        end
        chk(ptag, "bank_pwr_en", int'(bank_pwr_en), exp_pwr());
        for (int i = 0; i < NB; i++)
            chk("R4", $sformatf("remap[%0d]", i), int'(remap_tbl[i*IW +: IW]),
                (!m_on[i] || m_busy[i]) ? m_tgt[i] : i);
        for (int i = 0; i < NB; i++) begin
            lk_bank = IW'(i);
            #0.1;
            chk("R7", $sformatf("stall[%0d]", i), int'(lk_stall), m_busy[i]);
            chk("R5", $sformatf("eff[%0d]", i), int'(lk_eff),
                m_busy[i] ? i : (m_on[i] ? i : m_tgt[i]));
        end
    endtask

    task automatic run_epoch(input int pat, input int loss, input string ptag);
        int c [NB];
        int frozen, offc, lim, v, t, bd, eh, et, em;
        for (int i = 0; i < NB; i++) c[i] = pat_cnt(pat, i);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            for (int i = 0; i < NB; i++) acc_stb[i] = (k < c[i]);
        end
        @(negedge clk);
        acc_stb = '0;
        chk("R8", "pwr before tick", int'(bank_pwr_en), exp_pwr());
        perf_loss = 8'(loss);
        epoch_tick = 1'b1;
        // reference decision
        frozen = (pm_mode == 2'd2 && frz_period != 0 && m_phase < int'(frz_len));
        if (frz_period == 0 || m_phase + 1 >= int'(frz_period)) m_phase = 0;
        else m_phase = m_phase + 1;
        em = 0; eh = 0; et = 0;
        offc = 0;
        for (int i = 0; i < NB; i++) if (!m_on[i]) offc++;
        lim = (int'(max_off) > NB - 1) ? NB - 1 : int'(max_off);
        if (!frozen && loss > int'(loss_thr)) begin
            for (int i = NB - 1; i >= 0; i--) if (!m_on[i]) eh = i;
            if (offc > 0) begin
                m_on[eh] = 1; m_busy[eh] = 1; m_locked = 1;
                em = 1; et = m_tgt[eh];
            end
        end else if (!frozen && !(pm_mode == 2'd1 && m_locked != 0) && offc < lim) begin
            v = -1;
            for (int i = 0; i < NB; i++)
                if (m_on[i] && !m_busy[i] && !m_is_tgt(i) && (v < 0 || c[i] < c[v])) v = i;
            t = -1; bd = 0;
            if (v >= 0)
                for (int i = 0; i < NB; i++)
                    if (i != v && m_on[i]) begin
                        int d = iabs(i % 4 - v % 4) + iabs(i / 4 - v / 4);
                        if (t < 0 || d < bd) begin t = i; bd = d; end
                    end
            if (v >= 0 && t >= 0) begin
                m_on[v] = 0; m_tgt[v] = t;
            end
        end
        @(negedge clk);
        epoch_tick = 1'b0;
        check_all(ptag, em, eh, et);
    endtask

    task automatic ack(input int b);
        @(negedge clk);
        mig_ack = 1'b1;
        mig_ack_bank = IW'(b);
        m_busy[b] = 0;
        m_tgt[b] = b;
        @(negedge clk);
        mig_ack = 1'b0;
        check_all("R7", 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check_all("R1", 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        model_reset();
        // free mode, limit 4: ties, victim choice, limit, restart, equal loss
        pm_mode = 2'd0; max_off = 5'd4; loss_thr = 8'd20;
        do_reset();
        run_epoch(0, 5, "R2");
        for (int p = 1; p <= 4; p++) run_epoch(p, 5, "R2");
        run_epoch(5, 0, "R3");
        run_epoch(6, 30, "R6");
        run_epoch(7, 30, "R6");
        run_epoch(1, 0, "R11");
        ack(int'(mig_home));
        for (int b = 0; b < NB; b++) if (m_busy[b] != 0) ack(b);
        run_epoch(2, 20, "R3");
        run_epoch(3, 21, "R6");
        for (int b = 0; b < NB; b++) if (m_busy[b] != 0) ack(b);

        // free mode, no useful limit: shrink until eligibility runs out
        max_off = 5'd31;
        do_reset();
        for (int p = 0; p < 18; p++) run_epoch(p % 8, 0, "R11");
        run_epoch(4, 50, "R6");
        run_epoch(5, 0, "R9");

        // one-shot mode
        pm_mode = 2'd1; max_off = 5'd15;
        do_reset();
        for (int p = 1; p <= 3; p++) run_epoch(p, 2, "R9");
        run_epoch(2, 40, "R9");
        for (int b = 0; b < NB; b++) if (m_busy[b] != 0) ack(b);
        for (int p = 0; p < 3; p++) run_epoch(p, 0, "R9");
        run_epoch(6, 40, "R9");

        // windowed mode
        pm_mode = 2'd2; max_off = 5'd15; frz_period = 4'd4; frz_len = 4'd2;
        do_reset();
        for (int p = 0; p < 8; p++) run_epoch(p + 1, 0, "R10");
        for (int p = 0; p < 5; p++) run_epoch(p, 60, "R10");
        frz_period = 4'd0;
        run_epoch(3, 0, "R10");

        summary();
    end
endmodule